// File: doc/BRIEF.md
# DMA Bus Ownership Requester

This block is the borrowing side of a three-wire bus hand-over. It lets a DMA engine take a processor's bus for a short burst. A start command loads a transfer count, a first word address, a direction and a fill word, and the block then asks for the bus.

Once the processor grants the bus and the previous owner's address strobe and transfer acknowledge have both gone inactive, the block claims ownership with an acknowledge line. It then runs the requested number of word cycles on consecutive addresses. Write cycles drive the fill word. Read cycles return each word on a result port with a one-cycle valid pulse. Ownership is given back once the last cycle's strobes have gone inactive.

The tri-state buffers for the address, strobes and data are represented by enable outputs. These enables are active only while the block owns the bus.

Top module: `dma_bus_claim`

## Requirements
- R1: During and after reset, with no command accepted, `br_n`, `bgack_n`, `as_n` and `ds_n` are 1, and `addr_oe`, `strb_oe`, `data_oe` and `busy` are 0.
- R2: A `go` pulse with a nonzero `go_count`, seen at a rising edge while `busy` is 0, drives `br_n` to 0 and `busy` to 1 from that edge on.
- R3: `bgack_n` goes to 0 only at an edge where `bg_n` is 0 and both `bus_as_n` and `bus_dtack_n` are 1. It goes to 0 at the first such edge after the request. It stays 1 while the grant is missing or the previous owner's strobe or acknowledge is still active.
- R4: `br_n` returns to 1 at the same edge where `bgack_n` goes to 0, and is never 0 while `bgack_n` is 0.
- R5: `addr_oe` and `strb_oe` are 1 exactly while `bgack_n` is 0. `data_oe` is 1 exactly while `bgack_n` is 0 and the command is a write (`go_write` = 1).
- R6: Each bus cycle presents its address for one cycle with the strobes at 1. It then holds `as_n` and `ds_n` at 0 with the address stable until `bus_dtack_n` is seen at 0, plus one more cycle. A strobe therefore stays low for 2 + W cycles when the acknowledge comes W cycles late.
- R7: Exactly `go_count` bus cycles are run, at addresses `go_addr`, `go_addr`+1, and so on, one per cycle.
- R8: On writes, `rw_n` is 0 and `data_o` carries `go_fill` in every cycle. On reads, `rw_n` is 1, and the word on `data_i` in the cycle after the acknowledge is seen appears on `rd_data`, with `rd_valid` pulsed for one cycle, in address order.
- R9: `bgack_n` returns to 1 one edge after the last cycle's strobes have gone to 1. At that same edge `busy` drops to 0 and all enables go to 0.
- R10: A `go` seen while `busy` is 1 is ignored: the running burst keeps its count.
- R11: A `go` with `go_count` = 0 is ignored: `busy` and `br_n` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Start command strobe |
| go_count | input | CNT_W | Number of word cycles to run |
| go_addr | input | ADDR_W | First word address |
| go_write | input | 1 | 1 selects write cycles, 0 selects read cycles |
| go_fill | input | DATA_W | Word driven on every write cycle |
| busy | output | 1 | High from an accepted command until ownership is given back |
| br_n | output | 1 | Bus request, active low |
| bg_n | input | 1 | Bus grant from the processor, active low |
| bgack_n | output | 1 | Ownership acknowledge, active low |
| bus_as_n | input | 1 | Address strobe of the current bus owner, active low |
| bus_dtack_n | input | 1 | Transfer acknowledge on the bus, active low |
| addr_o | output | ADDR_W | Word address driven by this block |
| addr_oe | output | 1 | Output enable for the address |
| as_n | output | 1 | Own address strobe, active low |
| ds_n | output | 1 | Own data strobe, active low |
| rw_n | output | 1 | 1 for read cycles, 0 for write cycles |
| strb_oe | output | 1 | Output enable for the strobes and `rw_n` |
| data_o | output | DATA_W | Write data |
| data_oe | output | 1 | Output enable for the write data |
| data_i | input | DATA_W | Read data from the bus |
| rd_data | output | DATA_W | Word captured on a read cycle |
| rd_valid | output | 1 | One-cycle pulse marking a new `rd_data` |

## Verification
The checker assumes the slave keeps `bus_dtack_n` at 0 until it sees the strobes go back to 1. Without that, the strobe-hold property would fail on a correct design. It also assumes the processor does not take the grant away while the request is pending.

The bench's slave model obeys both rules. It raises its acknowledge only in the cycle after it sees `as_n` at 1, and it lifts `bg_n` only after `bgack_n` has been seen at 0. Wait states, grant delays and a lingering previous-owner strobe are varied between scenarios, all within those rules.

// File: rtl/dbc_pkg.sv
// Shared types for the DMA bus ownership requester.
// Assumes: nothing beyond the parameter values chosen by the top module.
package dbc_pkg;

    // Ownership phase of the request/grant/acknowledge sequence.
    typedef enum logic [1:0] {
        H_IDLE = 2'd0,
        H_REQ  = 2'd1,
        H_OWN  = 2'd2
    } hs_state_t;

    // Phase of one word cycle driven while the bus is owned.
    typedef enum logic [2:0] {
        E_IDLE   = 3'd0,
        E_ADDR   = 3'd1,
        E_STRB   = 3'd2,
        E_SAMPLE = 3'd3,
        E_NEG    = 3'd4
    } xfer_state_t;

endpackage

// File: rtl/dbc_handshake.sv
// Request/grant/acknowledge sequencer.
// Raises the request when a command is accepted, and claims the bus once the
// grant is present and the previous owner has let go of its strobe and
// acknowledge. Hands the bus back when the transfer engine reports the end.
// Assumes: accept is only raised while busy is low; the grant is not withdrawn
// while the request is pending.
module dbc_handshake
    import dbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic bg_n,
    input  logic bus_as_n,
    input  logic bus_dtack_n,
    input  logic xfer_done,
    output logic br_n,
    output logic bgack_n,
    output logic busy
);

    hs_state_t st_q;
    logic      br_q;
    logic      ack_q;
    logic      bus_free;

    // The previous owner has fully let go of the bus.
    always_comb bus_free = bus_as_n && bus_dtack_n;

    // Ownership sequence with registered request and acknowledge lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= H_IDLE;
            br_q  <= 1'b1;
            ack_q <= 1'b1;
        end else begin
            case (st_q)
                H_IDLE: begin
                    if (accept) begin
                        st_q <= H_REQ;
                        br_q <= 1'b0;
                    end
                end
                H_REQ: begin
                    if (!bg_n && bus_free) begin
                        st_q  <= H_OWN;
                        br_q  <= 1'b1;
                        ack_q <= 1'b0;
                    end
                end
                H_OWN: begin
                    if (xfer_done) begin
                        st_q  <= H_IDLE;
                        ack_q <= 1'b1;
                    end
                end
                default: begin
                    st_q  <= H_IDLE;
                    br_q  <= 1'b1;
                    ack_q <= 1'b1;
                end
            endcase
        end
    end

    // Drive the handshake outputs from the registered state.
    always_comb begin
        br_n    = br_q;
        bgack_n = ack_q;
        busy    = (st_q != H_IDLE);
    end

endmodule

// File: rtl/dbc_xfer.sv
// Word-cycle engine.
// Holds the loaded command and, while ownership is held, runs one word cycle
// after another: address, strobes until acknowledge, one sample cycle, then
// strobe release. Reports the end of the last cycle through done.
// Assumes: load and own are never high together; the acknowledge stays low
// until the strobes have been released.
module dbc_xfer
    import dbc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] load_fill,
    input  logic              own,
    input  logic              dtack_n,
    input  logic [DATA_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              as_n,
    output logic              ds_n,
    output logic              rw_n,
    output logic              is_write,
    output logic [DATA_W-1:0] data_o,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              done
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    xfer_state_t       st_q;
    logic [CNT_W-1:0]  rem_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] fill_q;
    logic [DATA_W-1:0] rdat_q;
    logic              wr_q;
    logic              armed_q;
    logic              rvld_q;
    logic              last;

    // The cycle being released is the final one of the burst.
    always_comb last = (rem_q == CNT_ONE);

    // Command storage and word-cycle sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= E_IDLE;
            rem_q   <= '0;
            addr_q  <= '0;
            fill_q  <= '0;
            rdat_q  <= '0;
            wr_q    <= 1'b0;
            armed_q <= 1'b0;
            rvld_q  <= 1'b0;
        end else begin
            rvld_q <= 1'b0;
            case (st_q)
                E_IDLE: begin
                    if (load) begin
                        rem_q   <= load_cnt;
                        addr_q  <= load_addr;
                        fill_q  <= load_fill;
                        wr_q    <= load_wr;
                        armed_q <= 1'b1;
                    end else if (armed_q && own) begin
                        armed_q <= 1'b0;
                        st_q    <= E_ADDR;
                    end
                end
                E_ADDR: st_q <= E_STRB;
                E_STRB: begin
                    if (!dtack_n) st_q <= E_SAMPLE;
                end
                E_SAMPLE: begin
                    if (!wr_q) begin
                        rdat_q <= data_i;
                        rvld_q <= 1'b1;
                    end
                    st_q <= E_NEG;
                end
                E_NEG: begin
                    rem_q <= rem_q - CNT_ONE;
                    if (last) begin
                        st_q <= E_IDLE;
                    end else begin
                        addr_q <= addr_q + ADDR_W'(1);
                        st_q   <= E_ADDR;
                    end
                end
                default: st_q <= E_IDLE;
            endcase
        end
    end

    // Decode strobes and the done pulse from the registered cycle phase.
    always_comb begin
        as_n     = !((st_q == E_STRB) || (st_q == E_SAMPLE));
        ds_n     = !((st_q == E_STRB) || (st_q == E_SAMPLE));
        rw_n     = !wr_q;
        is_write = wr_q;
        addr_o   = addr_q;
        data_o   = fill_q;
        rd_data  = rdat_q;
        rd_valid = rvld_q;
        done     = (st_q == E_NEG) && last;
    end

endmodule

// File: rtl/dbc_drive_en.sv
// Output-enable generation for the shared bus lines.
// Enables follow the ownership acknowledge so nothing is driven outside the
// owned window; write data is only enabled on write bursts.
// Assumes: bgack_n comes straight from a register.
module dbc_drive_en (
    input  logic bgack_n,
    input  logic is_write,
    output logic addr_oe,
    output logic strb_oe,
    output logic data_oe
);

    // Gate every enable with ownership.
    always_comb begin
        addr_oe = !bgack_n;
        strb_oe = !bgack_n;
        data_oe = !bgack_n && is_write;
    end

endmodule

// File: rtl/dma_bus_claim.sv
// DMA bus ownership requester, top level.
// Accepts a burst command, borrows the bus through the request/grant/
// acknowledge sequence, runs the word cycles and hands the bus back.
// Assumes: a slave that holds its acknowledge until the strobes negate, and a
// processor that keeps the grant until it has seen the acknowledge.
module dma_bus_claim #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CNT_W-1:0]  go_count,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic              go_write,
    input  logic [DATA_W-1:0] go_fill,
    output logic              busy,
    output logic              br_n,
    input  logic              bg_n,
    output logic              bgack_n,
    input  logic              bus_as_n,
    input  logic              bus_dtack_n,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_oe,
    output logic              as_n,
    output logic              ds_n,
    output logic              rw_n,
    output logic              strb_oe,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic accept;
    logic xfer_done;
    logic is_write;

    // Take a command only when idle and when it asks for at least one cycle.
    always_comb accept = go && (go_count != '0) && !busy;

    dbc_handshake u_hs (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .bg_n        (bg_n),
        .bus_as_n    (bus_as_n),
        .bus_dtack_n (bus_dtack_n),
        .xfer_done   (xfer_done),
        .br_n        (br_n),
        .bgack_n     (bgack_n),
        .busy        (busy)
    );

    dbc_xfer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_cnt  (go_count),
        .load_addr (go_addr),
        .load_wr   (go_write),
        .load_fill (go_fill),
        .own       (!bgack_n),
        .dtack_n   (bus_dtack_n),
        .data_i    (data_i),
        .addr_o    (addr_o),
        .as_n      (as_n),
        .ds_n      (ds_n),
        .rw_n      (rw_n),
        .is_write  (is_write),
        .data_o    (data_o),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .done      (xfer_done)
    );

    dbc_drive_en u_en (
        .bgack_n  (bgack_n),
        .is_write (is_write),
        .addr_oe  (addr_oe),
        .strb_oe  (strb_oe),
        .data_oe  (data_oe)
    );

endmodule

// File: rtl/dbc_checker.sv
// Protocol checker for the DMA bus ownership requester, bound to the top.
// Assumes: the slave holds its acknowledge until the strobes are released.
module dbc_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              br_n,
    input logic              bg_n,
    input logic              bgack_n,
    input logic              bus_as_n,
    input logic              bus_dtack_n,
    input logic [ADDR_W-1:0] addr_o,
    input logic              addr_oe,
    input logic              as_n,
    input logic              ds_n,
    input logic              strb_oe,
    input logic              data_oe
);

    // Nothing is driven and no strobe is active outside ownership (R1, R5).
    p_quiet_unowned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bgack_n |-> (!addr_oe && !strb_oe && !data_oe && as_n && ds_n));

    // Ownership is only claimed with a grant on a free bus (R3).
    p_claim_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bgack_n) |-> $past(!bg_n && bus_as_n && bus_dtack_n));

    // The request is never held while the bus is owned (R4).
    p_req_off_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bgack_n |-> br_n);

    // Strobes stay active until the acknowledge arrives (R6).
    p_strobe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && bus_dtack_n) |=> !as_n);

    // The address does not move while the strobe is active (R6).
    p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && !$past(as_n)) |-> $stable(addr_o));

    // Ownership is given back only after the strobes have been released (R9).
    p_release_after_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bgack_n) |-> (as_n && $past(as_n)));

endmodule

bind dma_bus_claim dbc_checker #(.ADDR_W(ADDR_W)) i_dbc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .br_n        (br_n),
    .bg_n        (bg_n),
    .bgack_n     (bgack_n),
    .bus_as_n    (bus_as_n),
    .bus_dtack_n (bus_dtack_n),
    .addr_o      (addr_o),
    .addr_oe     (addr_oe),
    .as_n        (as_n),
    .ds_n        (ds_n),
    .strb_oe     (strb_oe),
    .data_oe     (data_oe)
);

// File: tb/test_dma_bus_claim.sv
// Directed bench for the DMA bus ownership requester.
module test_dma_bus_claim;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic [CW-1:0] go_count = '0;
    logic [AW-1:0] go_addr = '0;
    logic          go_write = 1'b0;
    logic [DW-1:0] go_fill = '0;
    logic          busy, br_n, bgack_n;
    logic          bg_n = 1'b1;
    logic          bus_as_n = 1'b1;
    logic          bus_dtack_n = 1'b1;
    logic [AW-1:0] addr_o;
    logic          addr_oe, as_n, ds_n, rw_n, strb_oe, data_oe, rd_valid;
    logic [DW-1:0] data_o, data_i, rd_data;

    logic [DW-1:0] mem [0:255];
    logic [DW-1:0] rd_log [0:255];
    int checks = 0, errors = 0;
    int wait_st = 0, wcnt = 0, acks = 0, nrd = 0;
    int oe_bad = 0, addr_bad = 0, len_bad = 0, rel_bad = 0, slen = 0;
    logic cur_write = 1'b0;
    logic prev_as = 1'b1, prev_aoe = 1'b0, prev_bgack = 1'b1;
    logic [AW-1:0] prev_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign data_i = mem[addr_o[7:0]];

    dma_bus_claim #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_dma_bus_claim (
        .clk(clk), .rst_n(rst_n), .go(go), .go_count(go_count), .go_addr(go_addr),
        .go_write(go_write), .go_fill(go_fill), .busy(busy), .br_n(br_n), .bg_n(bg_n),
        .bgack_n(bgack_n), .bus_as_n(bus_as_n), .bus_dtack_n(bus_dtack_n),
        .addr_o(addr_o), .addr_oe(addr_oe), .as_n(as_n), .ds_n(ds_n), .rw_n(rw_n),
        .strb_oe(strb_oe), .data_o(data_o), .data_oe(data_oe), .data_i(data_i),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Slave model: acknowledge after wait_st extra cycles, release once strobes drop.
    always @(negedge clk) begin
        if (!as_n && strb_oe) begin
            if (bus_dtack_n) begin
                wcnt = wcnt + 1;
                if (wcnt > wait_st) begin
                    bus_dtack_n = 1'b0;
                    acks = acks + 1;
                    if (!rw_n) mem[addr_o[7:0]] = data_o;
                end
            end
        end else begin
            bus_dtack_n = 1'b1;
            wcnt = 0;
        end
    end

    // Monitor: enables, address set-up, strobe length, release order, read log.
    always @(negedge clk) begin
        if (rst_n) begin
            if (addr_oe !== !bgack_n || strb_oe !== !bgack_n ||
                data_oe !== (!bgack_n && cur_write)) oe_bad = oe_bad + 1;
            if (prev_as && !as_n && !(prev_aoe && prev_addr == addr_o)) addr_bad = addr_bad + 1;
            if (!as_n) slen = slen + 1;
            else if (!prev_as) begin
                if (slen != 2 + wait_st) len_bad = len_bad + 1;
                slen = 0;
            end
            if (bgack_n && !prev_bgack && !(as_n && prev_as)) rel_bad = rel_bad + 1;
            if (rd_valid) begin
                rd_log[nrd] = rd_data;
                nrd = nrd + 1;
            end
        end
        prev_as = as_n;
        prev_aoe = addr_oe;
        prev_addr = addr_o;
        prev_bgack = bgack_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(br_n && bgack_n && as_n && ds_n, "R1 handshake/strobes idle",
            {br_n, bgack_n, as_n, ds_n}, 15);
        chk(!addr_oe && !strb_oe && !data_oe && !busy, "R1 enables/busy off",
            {addr_oe, strb_oe, data_oe, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(br_n && bgack_n && !busy, "R1 after reset", {br_n, bgack_n, busy}, 6);
    endtask

    // One burst: n cycles at a, write or read, grant delay bgd, previous-owner
    // strobe lingering ash cycles after the grant, ws wait states, optional re-go.
    task automatic t_burst(input int n, input int a, input bit wr, input int fill,
                           input int bgd, input int ash, input int ws, input bit poke);
        int hold_bad = 0;
        int cyc = 0;
        logic [DW-1:0] after_val;
        after_val = mem[(a + n) & 255];
        wait_st = ws; cur_write = wr; acks = 0; nrd = 0;
        oe_bad = 0; addr_bad = 0; len_bad = 0; rel_bad = 0;
        go_count = CW'(n); go_addr = AW'(a); go_write = wr; go_fill = DW'(fill);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(!br_n && busy, "R2 request raised", {br_n, busy}, 1);
        for (int i = 0; i < bgd; i++) begin
            @(negedge clk);
            if (!bgack_n || br_n) hold_bad++;
        end
        bg_n = 1'b0;
        if (ash > 0) bus_as_n = 1'b0;
        for (int i = 0; i < ash; i++) begin
            @(negedge clk);
            if (!bgack_n) hold_bad++;
        end
        bus_as_n = 1'b1;
        chk(hold_bad == 0, "R3 no claim before grant and free bus", hold_bad, 0);
        @(negedge clk);
        chk(!bgack_n, "R3 claim on first free edge", bgack_n, 0);
        chk(br_n, "R4 request dropped at claim", br_n, 1);
        bg_n = 1'b1;
        if (poke) begin
            @(negedge clk);
            go_count = 8'd9; go_addr = 16'h00f0; go = 1'b1;
            @(negedge clk);
            go = 1'b0;
        end
        while (busy && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk(bgack_n && !addr_oe && !strb_oe && !data_oe, "R9 released and quiet",
            {bgack_n, addr_oe, strb_oe, data_oe}, 8);
        chk(rel_bad == 0, "R9 release after strobe negation", rel_bad, 0);
        chk(oe_bad == 0, "R5 enables follow ownership", oe_bad, 0);
        chk(addr_bad == 0 && len_bad == 0, "R6 address lead and strobe length",
            addr_bad + len_bad, 0);
        chk(acks == n, poke ? "R10 busy go ignored, cycle count" : "R7 cycle count", acks, n);
        if (wr) begin
            for (int k = 0; k < n; k++)
                chk(mem[(a + k) & 255] == DW'(fill), "R8 write data at address",
                    int'(mem[(a + k) & 255]), fill);
            chk(mem[(a + n) & 255] == after_val, "R7 no extra write", int'(mem[(a + n) & 255]),
                int'(after_val));
        end else begin
            chk(nrd == n, "R8 read pulse count", nrd, n);
            for (int k = 0; k < n; k++)
                chk(rd_log[k] == mem[(a + k) & 255], "R8 read word in order",
                    int'(rd_log[k]), int'(mem[(a + k) & 255]));
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_zero;
        go_count = '0; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(!busy && br_n, "R11 zero count ignored", {busy, br_n}, 1);
        repeat (3) @(negedge clk);
        chk(!busy && br_n && bgack_n, "R11 still idle", {busy, br_n, bgack_n}, 3);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = DW'(16'h0100 + i * 3);
        t_reset();
        t_burst(4, 16'h0010, 1'b1, 16'hA5C3, 2, 0, 0, 1'b0);
        t_burst(3, 16'h0040, 1'b0, 0, 0, 3, 2, 1'b0);
        t_burst(1, 16'h00ff, 1'b1, 16'h1234, 1, 1, 1, 1'b0);
        t_burst(5, 16'h0080, 1'b1, 16'h0F0F, 1, 0, 0, 1'b1);
        t_zero();
        t_burst(2, 16'h0010, 1'b0, 0, 3, 0, 1, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule